// File: doc/BRIEF.md
# Flag-Masked 8/16-bit Arithmetic and Logic Unit

This block is the combinational execute stage of a small 8-bit processor that also runs 16-bit arithmetic on register pairs. Each cycle it receives a 5-bit operation code, a width select, two operands and the current flag word. It returns a result, a strobe saying whether that result should be written back, and the next flag word.

The distinctive part is flag handling. Every operation class owns a fixed subset of the four flags: zero, carry, overflow and sign. Flags outside that subset pass through unchanged. Compare and bit-test produce flags but suppress write-back. The block has no operand fetch, addressing, register storage, multiply or divide. A decoder in the core maps instructions onto the operation codes below and routes operands in and results out.

Top module: `flagmask_alu`

## Requirements
- R1: `opSel` encodes: 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 AND, 5 OR, 6 compare, 7 XOR, 8 bit-test, 9 NOT, 10 negate, 11 increment, 12 decrement, 13 shift-left, 14 arithmetic-shift-left, 15 shift-right, 16 arithmetic-shift-right, 17 rotate-left, 18 rotate-left-through-carry, 19 rotate-right, 20 rotate-right-through-carry, 21 nibble-swap. Flag words (`flagsIn`, `flagsOut`) use bit 0 zero, bit 1 carry, bit 2 overflow, bit 3 sign.
- R2: Add and add-with-carry return A+B (+carry-in for code 1) truncated to the width and write it back. They set all four flags: carry is the carry-out, overflow is set when the operands share a sign that the result lacks, zero means the result is all zeros, and sign is the result MSB.
- R3: Subtract and subtract-with-borrow return A−B (−carry-in for code 3) and set all four flags. Carry means a borrow occurred. Overflow is set when the operand signs differ and the result sign differs from A's. Compare computes the same difference and flags with `resultWe` low.
- R4: With `wide`=1, codes 0,1,2,3,6,11,12 work on 16 bits: carry/borrow comes from bit 16 and sign is bit 15. With `wide`=0 they use bits [7:0] only.
- R5: Increment and decrement add or subtract one with wrap-around and update only the zero flag; carry, overflow and sign keep their incoming values.
- R6: AND, OR, XOR, NOT (~A) and bit-test (AND) update only zero and sign. Bit-test leaves `resultWe` low.
- R7: Negate returns 0−A[7:0] and sets all four flags as a subtraction from zero: carry is set for any nonzero A, and overflow is set only for A=0x80.
- R8: Shift-left, shift-right, rotate-left and rotate-right act on A[7:0]. The bit moved out goes to carry, the result sets zero and sign, and overflow is kept. The rotates keep the number of set bits.
- R9: The through-carry rotates form a 9-bit rotation: the incoming carry enters the vacated bit and the bit shifted out becomes the new carry.
- R10: Arithmetic-shift-left sets overflow when bits 7 and 6 of A differ. Arithmetic-shift-right keeps bit 7, moves bit 0 to carry and clears overflow. Both also set zero, carry and sign.
- R11: Nibble-swap returns A[3:0] in the high nibble and A[7:4] in the low nibble, writes back, and leaves all flags unchanged.
- R12: Byte-only codes ignore `wide` and the upper operand bytes, and drive result[15:8]=0. Codes 22–31 do nothing: `resultWe` is 0, the result is 0 and the flags pass through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opSel | input | 5 | Operation code (R1) |
| wide | input | 1 | 1 selects the 16-bit form where one exists |
| opA | input | 16 | First operand (minuend, shifted value) |
| opB | input | 16 | Second operand |
| flagsIn | input | 4 | Current flags {sign, overflow, carry, zero} |
| result | output | 16 | Operation result |
| resultWe | output | 1 | Result should be written back |
| flagsOut | output | 4 | Next flag values |

## Verification
Assertions inside the design check, for every operand set, the properties that follow from the operation class alone. Compare and bit-test never write back. Increment and decrement move only zero. The logic class never disturbs carry or overflow. Plain shifts and rotates never touch overflow. Swap and unused codes pass all flags through. Zero always matches a written result. The rotates conserve the number of set bits. The numeric content needs the bench's scenarios: exact sums, borrows, the signed-overflow cases at 0x7F/0x80 and 0x7FFF/0x8000, carry entering a 9-bit rotation, and the negate corner values.

// File: rtl/flagalu_pkg.sv
`timescale 1ns/1ps
package flagalu_pkg;

  localparam int FLAG_N = 4;
  localparam int FLG_Z  = 0;
  localparam int FLG_C  = 1;
  localparam int FLG_V  = 2;
  localparam int FLG_S  = 3;

  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,  OP_ADC  = 5'd1,  OP_SUB  = 5'd2,  OP_SBC  = 5'd3,
    OP_AND  = 5'd4,  OP_OR   = 5'd5,  OP_CMP  = 5'd6,  OP_XOR  = 5'd7,
    OP_TST  = 5'd8,  OP_NOT  = 5'd9,  OP_NEG  = 5'd10, OP_INC  = 5'd11,
    OP_DEC  = 5'd12, OP_SHL  = 5'd13, OP_SAL  = 5'd14, OP_SHR  = 5'd15,
    OP_SAR  = 5'd16, OP_ROL  = 5'd17, OP_ROLC = 5'd18, OP_ROR  = 5'd19,
    OP_RORC = 5'd20, OP_SWAP = 5'd21
  } aluOp_e;

  typedef enum logic [2:0] {
    CLS_NONE, CLS_ARITH, CLS_LOGIC, CLS_STEP, CLS_SHIFT, CLS_SWAP
  } aluClass_e;

  typedef enum logic [1:0] {LF_AND, LF_OR, LF_XOR, LF_NOT} logicFn_e;

  typedef enum logic [2:0] {
    SF_SHL, SF_SAL, SF_SHR, SF_SAR, SF_ROL, SF_ROLC, SF_ROR, SF_RORC
  } shiftFn_e;

  // Strobes from control to datapath
  typedef struct packed {
    aluClass_e          cls;
    logic               isSub;
    logic               useCarry;
    logic               negate;
    logicFn_e           logicFn;
    logic               stepDown;
    shiftFn_e           shiftFn;
    logic               wideOp;
    logic               writeBack;
    logic [FLAG_N-1:0]  flagMask;
  } aluStrobes_t;

  localparam logic [FLAG_N-1:0] MASK_ALL   = 4'b1111;
  localparam logic [FLAG_N-1:0] MASK_ZS    = 4'b1001;
  localparam logic [FLAG_N-1:0] MASK_ZCS   = 4'b1011;
  localparam logic [FLAG_N-1:0] MASK_Z     = 4'b0001;
  localparam logic [FLAG_N-1:0] MASK_NONE  = 4'b0000;

endpackage

// File: rtl/flagalu_ctrl.sv
`timescale 1ns/1ps
module flagalu_ctrl
  import flagalu_pkg::*;
(
  input  logic [4:0]  opSel,
  input  logic        wide,
  output aluStrobes_t strobes
);

  always_comb begin
    strobes           = '0;
    strobes.cls       = CLS_NONE;
    strobes.logicFn   = LF_AND;
    strobes.shiftFn   = SF_SHL;
    strobes.flagMask  = MASK_NONE;
    case (opSel)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP: begin
        strobes.cls       = CLS_ARITH;
        strobes.wideOp    = wide;
        strobes.isSub     = (opSel == OP_SUB) || (opSel == OP_SBC) || (opSel == OP_CMP);
        strobes.useCarry  = (opSel == OP_ADC) || (opSel == OP_SBC);
        strobes.writeBack = (opSel != OP_CMP);
        strobes.flagMask  = MASK_ALL;
      end
      OP_NEG: begin
        strobes.cls       = CLS_ARITH;
        strobes.isSub     = 1'b1;
        strobes.negate    = 1'b1;
        strobes.writeBack = 1'b1;
        strobes.flagMask  = MASK_ALL;
      end
      OP_AND, OP_OR, OP_XOR, OP_NOT, OP_TST: begin
        strobes.cls       = CLS_LOGIC;
        strobes.writeBack = (opSel != OP_TST);
        strobes.flagMask  = MASK_ZS;
        case (opSel)
          OP_OR:   strobes.logicFn = LF_OR;
          OP_XOR:  strobes.logicFn = LF_XOR;
          OP_NOT:  strobes.logicFn = LF_NOT;
          default: strobes.logicFn = LF_AND;
        endcase
      end
      OP_INC, OP_DEC: begin
        strobes.cls       = CLS_STEP;
        strobes.wideOp    = wide;
        strobes.stepDown  = (opSel == OP_DEC);
        strobes.writeBack = 1'b1;
        strobes.flagMask  = MASK_Z;
      end
      OP_SHL, OP_SAL, OP_SHR, OP_SAR, OP_ROL, OP_ROLC, OP_ROR, OP_RORC: begin
        strobes.cls       = CLS_SHIFT;
        strobes.writeBack = 1'b1;
        strobes.flagMask  = ((opSel == OP_SAL) || (opSel == OP_SAR)) ? MASK_ALL : MASK_ZCS;
        case (opSel)
          OP_SAL:  strobes.shiftFn = SF_SAL;
          OP_SHR:  strobes.shiftFn = SF_SHR;
          OP_SAR:  strobes.shiftFn = SF_SAR;
          OP_ROL:  strobes.shiftFn = SF_ROL;
          OP_ROLC: strobes.shiftFn = SF_ROLC;
          OP_ROR:  strobes.shiftFn = SF_ROR;
          OP_RORC: strobes.shiftFn = SF_RORC;
          default: strobes.shiftFn = SF_SHL;
        endcase
      end
      OP_SWAP: begin
        strobes.cls       = CLS_SWAP;
        strobes.writeBack = 1'b1;
      end
      default: ;
    endcase
  end

  // R3 / R6: flag-only classes never request write-back
  always_comb begin
    if (!$isunknown(opSel)) begin
      a_r3_cmp_no_write: assert (!(opSel == OP_CMP) || !strobes.writeBack);
      a_r6_tst_no_write: assert (!(opSel == OP_TST) || !strobes.writeBack);
    end
  end

endmodule

// File: rtl/flagalu_datapath.sv
`timescale 1ns/1ps
module flagalu_datapath
  import flagalu_pkg::*;
#(
  parameter int BYTE_W = 8
)(
  input  aluStrobes_t         strobes,
  input  logic [2*BYTE_W-1:0] opA,
  input  logic [2*BYTE_W-1:0] opB,
  input  logic                carryIn,
  output logic [2*BYTE_W-1:0] rawResult,
  output logic [FLAG_N-1:0]   rawFlags
);

  localparam int WIDE_W = 2 * BYTE_W;
  localparam int HALF_W = BYTE_W / 2;
  localparam logic [WIDE_W:0]   ONE_EXT   = {{WIDE_W{1'b0}}, 1'b1};
  localparam logic [WIDE_W-1:0] BYTE_MASK = {{BYTE_W{1'b0}}, {BYTE_W{1'b1}}};

  logic [BYTE_W-1:0] aByte;
  logic [BYTE_W-1:0] bByte;
  logic [WIDE_W-1:0] widthMask;
  logic [WIDE_W-1:0] lhs;
  logic [WIDE_W-1:0] rhs;
  logic [WIDE_W:0]   ext;
  logic [BYTE_W-1:0] byteRes;
  logic [BYTE_W-1:0] swapped;
  logic [WIDE_W-1:0] res;
  logic              cin;
  logic              carryOut;
  logic              ovf;
  logic              signA;
  logic              signB;
  logic              signR;
  int                msb;

  assign aByte = opA[BYTE_W-1:0];
  assign bByte = opB[BYTE_W-1:0];

  // nibble swap built from the byte width
  generate
    if (BYTE_W % 2 == 0) begin : g_swapEven
      assign swapped = {aByte[HALF_W-1:0], aByte[BYTE_W-1:HALF_W]};
    end else begin : g_swapOdd
      assign swapped = aByte;
    end
  endgenerate

  always_comb begin
    widthMask = strobes.wideOp ? {WIDE_W{1'b1}} : BYTE_MASK;
    msb       = strobes.wideOp ? WIDE_W - 1 : BYTE_W - 1;
    lhs       = strobes.negate ? '0 : (opA & widthMask);
    rhs       = strobes.negate ? {{BYTE_W{1'b0}}, aByte} : (opB & widthMask);
    cin       = strobes.useCarry & carryIn;
    ext       = '0;
    byteRes   = '0;
    res       = '0;
    carryOut  = 1'b0;
    ovf       = 1'b0;
    signA     = lhs[msb];
    signB     = rhs[msb];

    case (strobes.cls)
      CLS_ARITH: begin
        if (strobes.isSub) begin
          ext      = {1'b0, lhs} - {1'b0, rhs} - {{WIDE_W{1'b0}}, cin};
          carryOut = ext[WIDE_W];
        end else begin
          ext      = {1'b0, lhs} + {1'b0, rhs} + {{WIDE_W{1'b0}}, cin};
          carryOut = strobes.wideOp ? ext[WIDE_W] : ext[BYTE_W];
        end
        res = ext[WIDE_W-1:0] & widthMask;
      end
      CLS_STEP: begin
        ext = strobes.stepDown ? ({1'b0, lhs} - ONE_EXT) : ({1'b0, lhs} + ONE_EXT);
        res = ext[WIDE_W-1:0] & widthMask;
      end
      CLS_LOGIC: begin
        case (strobes.logicFn)
          LF_OR:   byteRes = aByte | bByte;
          LF_XOR:  byteRes = aByte ^ bByte;
          LF_NOT:  byteRes = ~aByte;
          default: byteRes = aByte & bByte;
        endcase
        res = {{BYTE_W{1'b0}}, byteRes};
      end
      CLS_SHIFT: begin
        case (strobes.shiftFn)
          SF_SHL, SF_SAL: begin
            byteRes  = {aByte[BYTE_W-2:0], 1'b0};
            carryOut = aByte[BYTE_W-1];
            ovf      = aByte[BYTE_W-1] ^ aByte[BYTE_W-2];
          end
          SF_SHR: begin
            byteRes  = {1'b0, aByte[BYTE_W-1:1]};
            carryOut = aByte[0];
          end
          SF_SAR: begin
            byteRes  = {aByte[BYTE_W-1], aByte[BYTE_W-1:1]};
            carryOut = aByte[0];
          end
          SF_ROL: begin
            byteRes  = {aByte[BYTE_W-2:0], aByte[BYTE_W-1]};
            carryOut = aByte[BYTE_W-1];
          end
          SF_ROLC: begin
            byteRes  = {aByte[BYTE_W-2:0], carryIn};
            carryOut = aByte[BYTE_W-1];
          end
          SF_ROR: begin
            byteRes  = {aByte[0], aByte[BYTE_W-1:1]};
            carryOut = aByte[0];
          end
          default: begin
            byteRes  = {carryIn, aByte[BYTE_W-1:1]};
            carryOut = aByte[0];
          end
        endcase
        res = {{BYTE_W{1'b0}}, byteRes};
      end
      CLS_SWAP: res = {{BYTE_W{1'b0}}, swapped};
      default:  res = '0;
    endcase

    signR = res[msb];
    if (strobes.cls == CLS_ARITH) begin
      if (strobes.isSub) ovf = (signA != signB) && (signR != signA);
      else               ovf = (signA == signB) && (signR != signA);
    end

    rawResult          = res;
    rawFlags[FLG_Z]    = (res == '0);
    rawFlags[FLG_C]    = carryOut;
    rawFlags[FLG_V]    = ovf;
    rawFlags[FLG_S]    = signR;
  end

  // R8: rotates within the byte keep the population count
  always_comb begin
    if (!$isunknown({strobes, opA})) begin
      a_r8_rotate_keeps_ones: assert (!((strobes.cls == CLS_SHIFT) &&
        ((strobes.shiftFn == SF_ROL) || (strobes.shiftFn == SF_ROR))) ||
        ($countones(rawResult) == $countones(aByte)));
    end
  end

endmodule

// File: rtl/flagmask_alu.sv
`timescale 1ns/1ps
module flagmask_alu
  import flagalu_pkg::*;
#(
  parameter int BYTE_W = 8
)(
  input  logic [4:0]          opSel,
  input  logic                wide,
  input  logic [2*BYTE_W-1:0] opA,
  input  logic [2*BYTE_W-1:0] opB,
  input  logic [3:0]          flagsIn,
  output logic [2*BYTE_W-1:0] result,
  output logic                resultWe,
  output logic [3:0]          flagsOut
);

  aluStrobes_t       strobes;
  logic [FLAG_N-1:0] rawFlags;

  flagalu_ctrl u_ctrl (
    .opSel   (opSel),
    .wide    (wide),
    .strobes (strobes)
  );

  flagalu_datapath #(.BYTE_W(BYTE_W)) u_datapath (
    .strobes   (strobes),
    .opA       (opA),
    .opB       (opB),
    .carryIn   (flagsIn[FLG_C]),
    .rawResult (result),
    .rawFlags  (rawFlags)
  );

  assign resultWe = strobes.writeBack;
  assign flagsOut = (rawFlags & strobes.flagMask) | (flagsIn & ~strobes.flagMask);

  always_comb begin
    if (!$isunknown({opSel, wide, opA, opB, flagsIn})) begin
      a_r5_step_only_zero: assert (!((opSel == OP_INC) || (opSel == OP_DEC)) ||
        (flagsOut[3:1] == flagsIn[3:1]));
      a_r6_logic_keeps_cv: assert (!((opSel == OP_AND) || (opSel == OP_OR) || (opSel == OP_XOR) ||
        (opSel == OP_NOT) || (opSel == OP_TST)) || (flagsOut[2:1] == flagsIn[2:1]));
      a_r8_plain_shift_keeps_v: assert (!((opSel == OP_SHL) || (opSel == OP_SHR) ||
        (opSel == OP_ROL) || (opSel == OP_ROR) || (opSel == OP_ROLC) || (opSel == OP_RORC)) ||
        (flagsOut[FLG_V] == flagsIn[FLG_V]));
      a_r11_swap_keeps_flags: assert (!(opSel == OP_SWAP) || (flagsOut == flagsIn));
      a_r12_unused_idle: assert (!(opSel > 5'd21) || (!resultWe && (flagsOut == flagsIn)));
      a_r2_zero_tracks_result: assert (!(resultWe && (opSel != OP_SWAP)) ||
        (flagsOut[FLG_Z] == (result == '0)));
    end
  end

endmodule

// File: tb/flagmask_alu_bench.sv
`timescale 1ns/1ps
module flagmask_alu_bench;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [4:0]  opSel = 5'd31;
  logic        wide = 1'b0;
  logic [15:0] opA = '0;
  logic [15:0] opB = '0;
  logic [3:0]  flagsIn = '0;
  logic [15:0] result;
  logic        resultWe;
  logic [3:0]  flagsOut;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [20:0] expQ[$];
  string       tagQ[$];

  flagmask_alu u_flagmask_alu (
    .opSel(opSel), .wide(wide), .opA(opA), .opB(opB), .flagsIn(flagsIn),
    .result(result), .resultWe(resultWe), .flagsOut(flagsOut)
  );

  function automatic int unsigned bitOf(int unsigned val, int unsigned n);
    return (val >> (n - 1)) & 1;
  endfunction

  // Reference: returns {we, result[15:0], flags{S,V,C,Z}}
  function automatic logic [20:0] refModel(logic [4:0] op, logic w, logic [15:0] a,
                                           logic [15:0] b, logic [3:0] f);
    int unsigned n, lim, ua, ub, ci, s;
    logic [15:0] r;
    logic [7:0]  x;
    logic [3:0]  fo;
    logic        we, c, v;
    fo = f; we = 1'b0; r = '0; x = a[7:0]; c = 1'b0; v = 1'b0;
    case (op)
      5'd0, 5'd1, 5'd2, 5'd3, 5'd6, 5'd10: begin
        n   = (w && op != 5'd10) ? 16 : 8;
        lim = 1 << n;
        ua  = (op == 5'd10) ? 0 : (32'(a) & (lim - 1));
        ub  = (op == 5'd10) ? 32'(x) : (32'(b) & (lim - 1));
        ci  = (op == 5'd1 || op == 5'd3) ? 32'(f[1]) : 0;
        if (op == 5'd0 || op == 5'd1) begin
          s = ua + ub + ci;
          c = (s >= lim);
          s = s % lim;
          v = (bitOf(ua, n) == bitOf(ub, n)) && (bitOf(s, n) != bitOf(ua, n));
        end else begin
          c = (ua < ub + ci);
          s = (ua + 2 * lim - ub - ci) % lim;
          v = (bitOf(ua, n) != bitOf(ub, n)) && (bitOf(s, n) != bitOf(ua, n));
        end
        r  = 16'(s);
        we = (op != 5'd6);
        fo = {bitOf(s, n) == 1, v, c, s == 0};
      end
      5'd11, 5'd12: begin
        n   = w ? 16 : 8;
        lim = 1 << n;
        ua  = 32'(a) & (lim - 1);
        s   = (op == 5'd11) ? (ua + 1) % lim : (ua + lim - 1) % lim;
        r   = 16'(s);
        we  = 1'b1;
        fo  = {f[3:1], s == 0};
      end
      5'd4, 5'd5, 5'd7, 5'd8, 5'd9: begin
        case (op)
          5'd5:    r = {8'h00, x | b[7:0]};
          5'd7:    r = {8'h00, x ^ b[7:0]};
          5'd9:    r = {8'h00, ~x};
          default: r = {8'h00, x & b[7:0]};
        endcase
        we = (op != 5'd8);
        fo = {r[7], f[2], f[1], r == 16'h0};
      end
      5'd13, 5'd14, 5'd15, 5'd16, 5'd17, 5'd18, 5'd19, 5'd20: begin
        v = f[2];
        case (op)
          5'd13:   begin r = {8'h00, x << 1};             c = x[7]; end
          5'd14:   begin r = {8'h00, x << 1};             c = x[7]; v = x[7] ^ x[6]; end
          5'd15:   begin r = {8'h00, x >> 1};             c = x[0]; end
          5'd16:   begin r = {8'h00, x[7], x[7:1]};       c = x[0]; v = 1'b0; end
          5'd17:   begin r = {8'h00, x[6:0], x[7]};       c = x[7]; end
          5'd18:   begin r = {8'h00, x[6:0], f[1]};       c = x[7]; end
          5'd19:   begin r = {8'h00, x[0], x[7:1]};       c = x[0]; end
          default: begin r = {8'h00, f[1], x[7:1]};       c = x[0]; end
        endcase
        we = 1'b1;
        fo = {r[7], v, c, r == 16'h0};
      end
      5'd21: begin
        r  = {8'h00, x[3:0], x[7:4]};
        we = 1'b1;
      end
      default: ;
    endcase
    return {we, r, fo};
  endfunction

  function automatic string tagFor(logic [4:0] op);
    case (op)
      5'd0, 5'd1:                  return "R2";
      5'd2, 5'd3, 5'd6:            return "R3";
      5'd4, 5'd5, 5'd7, 5'd8, 5'd9: return "R6";
      5'd10:                       return "R7";
      5'd11, 5'd12:                return "R5";
      5'd14, 5'd16:                return "R10";
      5'd18, 5'd20:                return "R9";
      5'd13, 5'd15, 5'd17, 5'd19:  return "R8";
      5'd21:                       return "R11";
      default:                     return "R12";
    endcase
  endfunction

  // Driver: apply one operation and queue its expected outcome
  task automatic drive(string tag, logic [4:0] op, logic w, logic [15:0] a,
                       logic [15:0] b, logic [3:0] f);
    @(posedge clk);
    #1;
    opSel = op; wide = w; opA = a; opB = b; flagsIn = f;
    expQ.push_back(refModel(op, w, a, b, f));
    tagQ.push_back(tag);
  endtask

  // Monitor: compare at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (expQ.size() > 0) begin
        logic [20:0] exp;
        logic [20:0] got;
        string       tag;
        exp = expQ.pop_front();
        tag = tagQ.pop_front();
        got = {resultWe, result, flagsOut};
        checks++;
        if (got !== exp) begin
          errors++;
          $display("FAIL %s op=%0d wide=%0b a=%h b=%h fin=%b : got we=%0b res=%h flags=%b, expected we=%0b res=%h flags=%b",
                   tag, opSel, wide, opA, opB, flagsIn,
                   got[20], got[19:4], got[3:0], exp[20], exp[19:4], exp[3:0]);
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL R1 watchdog: got no completion, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // idle state: unused code
    drive("R12", 5'd31, 1'b0, 16'h0000, 16'h0000, 4'b0000);
    drive("R12", 5'd22, 1'b1, 16'h1234, 16'h5678, 4'b1010);
    // base-group encoding order
    for (int op = 0; op < 8; op++) drive("R1", 5'(op), 1'b0, 16'h00C5, 16'h003A, 4'b0010);
    // add
    drive("R2", 5'd0, 1'b0, 16'h007F, 16'h0001, 4'b0000);
    drive("R2", 5'd0, 1'b0, 16'h00FF, 16'h0001, 4'b0000);
    drive("R2", 5'd1, 1'b0, 16'h0010, 16'h0020, 4'b0010);
    drive("R2", 5'd0, 1'b0, 16'h0080, 16'h0080, 4'b0000);
    // subtract and compare
    drive("R3", 5'd2, 1'b0, 16'h0000, 16'h0001, 4'b0000);
    drive("R3", 5'd2, 1'b0, 16'h0080, 16'h0001, 4'b0000);
    drive("R3", 5'd3, 1'b0, 16'h0005, 16'h0005, 4'b0010);
    drive("R3", 5'd6, 1'b0, 16'h0042, 16'h0042, 4'b1110);
    // 16-bit forms
    drive("R4", 5'd0, 1'b1, 16'hFFFF, 16'h0001, 4'b0000);
    drive("R4", 5'd0, 1'b1, 16'h7FFF, 16'h0001, 4'b0000);
    drive("R4", 5'd6, 1'b1, 16'h1000, 16'h2000, 4'b0000);
    drive("R4", 5'd3, 1'b1, 16'h8000, 16'h0000, 4'b0010);
    drive("R4", 5'd12, 1'b1, 16'h0000, 16'h0000, 4'b0000);
    drive("R4", 5'd11, 1'b0, 16'h12FF, 16'h0000, 4'b0000);
    // increment / decrement
    drive("R5", 5'd11, 1'b0, 16'h00FF, 16'h0000, 4'b1110);
    drive("R5", 5'd12, 1'b0, 16'h0001, 16'h0000, 4'b0100);
    // logic
    drive("R6", 5'd4, 1'b0, 16'h00F0, 16'h000F, 4'b0110);
    drive("R6", 5'd5, 1'b0, 16'h0080, 16'h0001, 4'b0000);
    drive("R6", 5'd7, 1'b0, 16'h00AA, 16'h00AA, 4'b0010);
    drive("R6", 5'd9, 1'b0, 16'h0000, 16'h0000, 4'b0100);
    drive("R6", 5'd8, 1'b0, 16'h0081, 16'h0080, 4'b0000);
    // negate
    drive("R7", 5'd10, 1'b0, 16'h0000, 16'h0000, 4'b0000);
    drive("R7", 5'd10, 1'b0, 16'h0080, 16'h0000, 4'b0000);
    drive("R7", 5'd10, 1'b1, 16'hFF01, 16'h0000, 4'b0000);
    // plain shifts and rotates
    drive("R8", 5'd13, 1'b0, 16'h0081, 16'h0000, 4'b0100);
    drive("R8", 5'd15, 1'b0, 16'h0001, 16'h0000, 4'b0000);
    drive("R8", 5'd17, 1'b0, 16'h0080, 16'h0000, 4'b0100);
    drive("R8", 5'd19, 1'b0, 16'h0001, 16'h0000, 4'b0000);
    // through-carry rotates
    drive("R9", 5'd18, 1'b0, 16'h0000, 16'h0000, 4'b0010);
    drive("R9", 5'd18, 1'b0, 16'h0080, 16'h0000, 4'b0000);
    drive("R9", 5'd20, 1'b0, 16'h0000, 16'h0000, 4'b0010);
    drive("R9", 5'd20, 1'b0, 16'h0001, 16'h0000, 4'b0000);
    // arithmetic shifts
    drive("R10", 5'd14, 1'b0, 16'h0040, 16'h0000, 4'b0000);
    drive("R10", 5'd14, 1'b0, 16'h00C0, 16'h0000, 4'b0100);
    drive("R10", 5'd16, 1'b0, 16'h0081, 16'h0000, 4'b0100);
    // swap
    drive("R11", 5'd21, 1'b0, 16'h003C, 16'h0000, 4'b1011);
    drive("R11", 5'd21, 1'b1, 16'hAB5A, 16'h0000, 4'b0100);
    // byte ops ignore wide and upper bytes
    drive("R12", 5'd5, 1'b1, 16'hFF01, 16'hEE02, 4'b0000);
    drive("R12", 5'd13, 1'b1, 16'h7F40, 16'h0000, 4'b0000);
    // sweep
    for (int i = 0; i < 600; i++) begin
      logic [4:0] op;
      op = 5'($urandom_range(0, 31));
      drive(tagFor(op), op, 1'($urandom), 16'($urandom), 16'($urandom), 4'($urandom));
    end
    repeat (3) @(posedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule